// File: doc/BRIEF.md
# Register-Mapped Multiply-Accumulate Unit

This block is a small arithmetic coprocessor that sits on a plain register bus next to a 16-bit processor core. Software sets a mode in a control register and then writes operands. The unit counts those writes. Once enough operands have arrived, it starts the selected operation by itself, with no separate start command. The available operations are multiply, multiply-accumulate, multiply-subtract, multiply-negate and square. Each one runs on signed two's-complement or unsigned operands.

The result goes into a three-word accumulator, unless a control bit blocks that writeback. A two-word result copy is refreshed by every operation. An overflow flag records carry, borrow or range errors and stays set until software clears it. The accumulator words, the operands and the result copy can all be read over the bus. The accumulator words can also be written over the bus.

Register addresses: 0 control, 1 operand A, 2 operand B, 3 to 3+ACC_WORDS-1 accumulator words (least significant first), then two read-only result words (least significant first).

Top module: `mac_unit`

## Requirements
- R1: After reset, every readable register returns zero and the overflow flag is low.
- R2: Control bit layout: bit 0 unsigned select (1 unsigned, 0 signed), bit 1 subtract/negate, bit 2 accumulate enable, bit 3 square, bit 4 single-operand start, bit 5 accumulator write block, bit 6 clear operands, bit 7 overflow. Bits 0-5 read back as written, bit 6 reads zero, and bit 7 reads the overflow flag.
- R3: With bits 3 and 4 clear, an operation starts only after at least one write to operand A and at least one write to operand B, in either order. Repeated writes to only one operand start nothing.
- R4: With bit 4 set and bit 3 clear, each write to either operand starts an operation, using the other operand's stored value.
- R5: With bit 3 set, a write to either operand address stores the value in both operands and starts a square, whatever bit 4 holds.
- R6: A control write discards any partial operand count. It also zeroes both operands when bit 6 is set; otherwise the operands keep their values.
- R7: The result is visible one clock after the clock edge that captures the triggering operand write, and not before.
- R8: Accumulate-off operations store the product (bit 1 clear) or its negation (bit 1 set). Accumulate-on operations store accumulator plus product (bit 1 clear) or accumulator minus product (bit 1 set). The product is sign-extended in signed mode and zero-extended in unsigned mode. All results are taken modulo 2^(16*ACC_WORDS).
- R9: With bit 5 set, an operation leaves the accumulator unchanged.
- R10: Every operation loads the two result words with the low two words of its result, whatever bit 5 holds.
- R11: The overflow flag is set in four cases: an unsigned accumulate carries out of the accumulator; an unsigned subtract borrows; a signed accumulate or subtract leaves the two's-complement range of the accumulator; an unsigned negate is requested (its stored result is still the two's-complement negation).
- R12: The overflow flag is sticky. Only a control write with bit 7 at zero clears it.
- R13: Bus writes to accumulator words replace them. Writes to the result words are ignored. Changing the unsigned select leaves the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Register address for reads and writes |
| busWrEn | input | 1 | Write strobe, one write per clock |
| busWrData | input | OP_W | Write data |
| busRdData | output | OP_W | Read data for busAddr (combinational) |
| ovfFlag | output | 1 | Sticky overflow flag |
| accOut | output | OP_W*ACC_WORDS | Accumulator contents |

## Verification
The bench builds the unit with 8-bit operands and three accumulator words, which gives a 24-bit accumulator. At that size, preloading the accumulator near its limits makes unsigned carry, borrow and signed range overflow reachable within a few hundred products. Eight arithmetic modes each run over all pairs drawn from a sixteen-value corner set (zero, one, the sign boundaries, all-ones, alternating patterns). Every 8-bit value is squared in both signed and unsigned mode. Directed sequences cover operand counting, counter reset, operand clearing, write blocking, sticky overflow and start timing.

// File: rtl/mac_unit_pkg.sv
package mac_unit_pkg;

  // Control register bit positions
  localparam int CB_UNS   = 0;
  localparam int CB_SUB   = 1;
  localparam int CB_ACC   = 2;
  localparam int CB_SQR   = 3;
  localparam int CB_ONE   = 4;
  localparam int CB_BLOCK = 5;
  localparam int CB_CLR   = 6;
  localparam int CB_OVF   = 7;

  // Fixed register addresses; accumulator and result words follow
  localparam int RA_CTRL = 0;
  localparam int RA_OPA  = 1;
  localparam int RA_OPB  = 2;
  localparam int RA_ACC0 = 3;

  typedef struct packed {
    logic uns;
    logic sub;
    logic acc;
    logic block;
  } mac_mode_t;

  typedef struct packed {
    logic      loadA;
    logic      loadB;
    logic      clearOps;
    logic      clearOvf;
    logic      accWr;
    logic      fire;
    mac_mode_t mode;
  } mac_strobe_t;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_unit_pkg::*;
#(
  parameter int ACC_WORDS = 3,
  parameter int ADDR_W    = 3,
  parameter int IDX_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        ctrlData,
  output mac_strobe_t       stb,
  output logic [IDX_W-1:0]  accSel,
  output logic [5:0]        modeBits
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(RA_CTRL);
  localparam logic [ADDR_W-1:0] A_OPA  = ADDR_W'(RA_OPA);
  localparam logic [ADDR_W-1:0] A_OPB  = ADDR_W'(RA_OPB);
  localparam logic [ADDR_W-1:0] A_ACC0 = ADDR_W'(RA_ACC0);
  localparam logic [ADDR_W-1:0] A_SH0  = ADDR_W'(RA_ACC0 + ACC_WORDS);

  logic [5:0] modeQ;
  logic       gotAQ, gotBQ, fireQ;
  mac_mode_t  fireModeQ;
  logic       ctrlWr, wrA, wrB, trigger;

  assign ctrlWr = busWrEn && (busAddr == A_CTRL);
  assign wrA    = busWrEn && (busAddr == A_OPA);
  assign wrB    = busWrEn && (busAddr == A_OPB);

  assign trigger = (wrA || wrB) &&
                   (modeQ[CB_SQR] || modeQ[CB_ONE] || (wrA && gotBQ) || (wrB && gotAQ));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ     <= '0;
      gotAQ     <= 1'b0;
      gotBQ     <= 1'b0;
      fireQ     <= 1'b0;
      fireModeQ <= '0;
    end else begin
      if (ctrlWr) modeQ <= ctrlData[5:0];
      if (ctrlWr || trigger) begin
        gotAQ <= 1'b0;
        gotBQ <= 1'b0;
      end else begin
        if (wrA) gotAQ <= 1'b1;
        if (wrB) gotBQ <= 1'b1;
      end
      fireQ     <= trigger;
      fireModeQ <= '{uns: modeQ[CB_UNS], sub: modeQ[CB_SUB],
                     acc: modeQ[CB_ACC], block: modeQ[CB_BLOCK]};
    end
  end

  assign stb.loadA    = wrA || (modeQ[CB_SQR] && wrB);
  assign stb.loadB    = wrB || (modeQ[CB_SQR] && wrA);
  assign stb.clearOps = ctrlWr && ctrlData[CB_CLR];
  assign stb.clearOvf = ctrlWr && !ctrlData[CB_OVF];
  assign stb.accWr    = busWrEn && (busAddr >= A_ACC0) && (busAddr < A_SH0);
  assign stb.fire     = fireQ;
  assign stb.mode     = fireModeQ;
  assign accSel       = IDX_W'(busAddr - A_ACC0);
  assign modeBits     = modeQ;

  AST_FIRE_NEEDS_OPERAND: assert property (@(posedge clk) disable iff (!rstN)
    fireQ |-> $past(busWrEn && (busAddr == A_OPA || busAddr == A_OPB))); // R7
  AST_CTRL_WRITE_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (!gotAQ && !gotBQ && !fireQ)); // R6
  AST_SQUARE_FIRES: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ[CB_SQR] && (wrA || wrB)) |=> fireQ); // R5
  AST_SINGLE_FIRES: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ[CB_ONE] && (wrA || wrB)) |=> fireQ); // R4
  AST_PAIR_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    (!modeQ[CB_SQR] && !modeQ[CB_ONE] && wrA && !gotBQ) |=> !fireQ); // R3

endmodule

// File: rtl/mac_dp.sv
module mac_dp
  import mac_unit_pkg::*;
#(
  parameter int OP_W      = 16,
  parameter int ACC_WORDS = 3,
  parameter int IDX_W     = 2,
  localparam int ACC_W    = OP_W * ACC_WORDS,
  localparam int PROD_W   = 2 * OP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  mac_strobe_t       stb,
  input  logic [IDX_W-1:0]  accSel,
  input  logic [OP_W-1:0]   wrData,
  output logic [OP_W-1:0]   opA,
  output logic [OP_W-1:0]   opB,
  output logic [ACC_W-1:0]  accFlat,
  output logic [PROD_W-1:0] shadow,
  output logic              ovf
);

  localparam int EXT_W = ACC_W - PROD_W;
  localparam int TOPB  = ACC_W - 1;

  logic [ACC_WORDS-1:0][OP_W-1:0] accQ;
  logic [OP_W-1:0]          opAQ, opBQ;
  logic [PROD_W-1:0]        shadowQ, prodU;
  logic signed [PROD_W-1:0] prodS;
  logic [ACC_W-1:0]         prodExt, addend, res;
  logic [ACC_W:0]           sumX;
  logic                     ovfQ, ovfSet;

  assign accFlat = accQ;

  assign prodU   = PROD_W'(opAQ) * PROD_W'(opBQ);
  assign prodS   = PROD_W'($signed(opAQ)) * PROD_W'($signed(opBQ));
  assign prodExt = stb.mode.uns ? {{EXT_W{1'b0}}, prodU}
                                : {{EXT_W{prodS[PROD_W-1]}}, prodS};
  assign addend  = stb.mode.sub ? ~prodExt : prodExt;
  assign sumX    = {1'b0, accFlat} + {1'b0, addend} + {{ACC_W{1'b0}}, stb.mode.sub};

  always_comb begin
    if (stb.mode.acc) begin
      res = sumX[ACC_W-1:0];
      if (stb.mode.uns)
        ovfSet = stb.mode.sub ? !sumX[ACC_W] : sumX[ACC_W];
      else if (stb.mode.sub)
        ovfSet = (accFlat[TOPB] != prodExt[TOPB]) && (res[TOPB] != accFlat[TOPB]);
      else
        ovfSet = (accFlat[TOPB] == prodExt[TOPB]) && (res[TOPB] != accFlat[TOPB]);
    end else begin
      res    = stb.mode.sub ? (ACC_W'(0) - prodExt) : prodExt;
      ovfSet = stb.mode.sub && stb.mode.uns;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opAQ    <= '0;
      opBQ    <= '0;
      accQ    <= '0;
      shadowQ <= '0;
      ovfQ    <= 1'b0;
    end else begin
      if (stb.clearOps) begin
        opAQ <= '0;
        opBQ <= '0;
      end else begin
        if (stb.loadA) opAQ <= wrData;
        if (stb.loadB) opBQ <= wrData;
      end
      if (stb.fire && !stb.mode.block) accQ <= res;
      if (stb.accWr) accQ[accSel] <= wrData;
      if (stb.fire) shadowQ <= res[PROD_W-1:0];
      ovfQ <= (ovfQ && !stb.clearOvf) || (stb.fire && ovfSet);
    end
  end

  assign opA    = opAQ;
  assign opB    = opBQ;
  assign shadow = shadowQ;
  assign ovf    = ovfQ;

  AST_BLOCKED_ACC_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fire && stb.mode.block && !stb.accWr) |=> $stable(accQ)); // R9
  AST_SHADOW_ONLY_ON_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    !stb.fire |=> $stable(shadowQ)); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfQ && !stb.clearOvf) |=> ovfQ); // R12
  AST_UNSIGNED_NEGATE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fire && !stb.mode.acc && stb.mode.sub && stb.mode.uns) |=> ovfQ); // R11
  AST_CLEAR_OPERANDS: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearOps |=> (opAQ == '0 && opBQ == '0)); // R6

endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_unit_pkg::*;
#(
  parameter int OP_W      = 16,
  parameter int ACC_WORDS = 3,
  localparam int ADDR_W   = $clog2(ACC_WORDS + 5),
  localparam int ACC_W    = OP_W * ACC_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [OP_W-1:0]   busWrData,
  output logic [OP_W-1:0]   busRdData,
  output logic              ovfFlag,
  output logic [ACC_W-1:0]  accOut
);

  localparam int IDX_W   = (ACC_WORDS > 1) ? $clog2(ACC_WORDS) : 1;
  localparam int PROD_W  = 2 * OP_W;
  localparam int SH_BASE = RA_ACC0 + ACC_WORDS;

  mac_strobe_t       stb;
  logic [IDX_W-1:0]  accSel;
  logic [5:0]        modeBits;
  logic [OP_W-1:0]   opA, opB;
  logic [ACC_W-1:0]  accFlat;
  logic [PROD_W-1:0] shadow;
  logic              ovf;

  mac_ctrl #(.ACC_WORDS(ACC_WORDS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .ctrlData(busWrData[7:0]), .stb(stb), .accSel(accSel), .modeBits(modeBits)
  );

  mac_dp #(.OP_W(OP_W), .ACC_WORDS(ACC_WORDS), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .accSel(accSel), .wrData(busWrData),
    .opA(opA), .opB(opB), .accFlat(accFlat), .shadow(shadow), .ovf(ovf)
  );

  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_W'(RA_CTRL)) begin
      busRdData[5:0]    = modeBits;
      busRdData[CB_OVF] = ovf;
    end
    if (busAddr == ADDR_W'(RA_OPA)) busRdData = opA;
    if (busAddr == ADDR_W'(RA_OPB)) busRdData = opB;
    for (int w = 0; w < ACC_WORDS; w++)
      if (busAddr == ADDR_W'(RA_ACC0 + w)) busRdData = accFlat[w*OP_W +: OP_W];
    for (int s = 0; s < 2; s++)
      if (busAddr == ADDR_W'(SH_BASE + s)) busRdData = shadow[s*OP_W +: OP_W];
  end

  assign ovfFlag = ovf;
  assign accOut  = accFlat;

endmodule

// File: tb/mac_unit_bench.sv
module mac_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OP_W = 8;
  localparam int ACC_WORDS = 3;
  localparam int ADDR_W = 3;
  localparam int ACC_W = OP_W * ACC_WORDS;
  localparam int MASK = (1 << ACC_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic [OP_W-1:0] busWrData = '0;
  logic [OP_W-1:0] busRdData;
  logic ovfFlag;
  logic [ACC_W-1:0] accOut;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;
  int mAcc = 0;
  int vals[16] = '{0, 1, 2, 3, 8'h7f, 8'h80, 8'h81, 8'hfe,
                   8'hff, 8'h55, 8'haa, 8'h40, 8'hc0, 8'h10, 8'h33, 8'hf0};

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_unit #(.OP_W(OP_W), .ACC_WORDS(ACC_WORDS)) u_mac_unit (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .ovfFlag(ovfFlag), .accOut(accOut)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    busAddr = ADDR_W'(a);
    busWrData = OP_W'(d);
    busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    busAddr = ADDR_W'(a);
    #1;
    d = int'(busRdData);
  endtask

  task automatic rdAcc(output int v);
    int w0, w1, w2;
    rd(3, w0); rd(4, w1); rd(5, w2);
    v = w0 | (w1 << 8) | (w2 << 16);
  endtask

  task automatic rdShadow(output int v);
    int s0, s1;
    rd(6, s0); rd(7, s1);
    v = s0 | (s1 << 8);
  endtask

  task automatic loadAcc(input int v);
    wr(3, v & 255); wr(4, (v >> 8) & 255); wr(5, (v >> 16) & 255);
    mAcc = v & MASK;
  endtask

  function automatic int sx8(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  function automatic int sx24(input int v);
    return (v >= (1 << 23)) ? v - (1 << 24) : v;
  endfunction

  // Expected result and overflow from the arithmetic rules (R8, R11)
  task automatic model(input int mode, input int a, input int b,
                       output int res, output int ov);
    bit uns, sub, acc;
    int p, t;
    uns = mode[0]; sub = mode[1]; acc = mode[2];
    p = uns ? a * b : sx8(a) * sx8(b);
    ov = 0;
    if (acc) begin
      t = uns ? mAcc : sx24(mAcc);
      t = sub ? t - p : t + p;
      if (uns) ov = (t > MASK || t < 0) ? 1 : 0;
      else ov = (t > 8388607 || t < -8388608) ? 1 : 0;
    end else begin
      t = sub ? -p : p;
      ov = (sub && uns) ? 1 : 0;
    end
    res = t & MASK;
  endtask

  task automatic runOp(input int mode, input int a, input int b, input string tag);
    int res, ov, accV, shV;
    model(mode, a, b, res, ov);
    wr(0, mode);
    wr(1, a);
    wr(2, b);
    @(negedge clk);
    if (!mode[5]) mAcc = res;
    rdAcc(accV);
    check({tag, " R8 accumulator"}, accV, mAcc);
    rdShadow(shV);
    check({tag, " R10 result words"}, shV, res & 16'hffff);
    check({tag, " R11 overflow"}, int'(ovfFlag), ov);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    int v, v2, sh0;
    int modes[8] = '{0, 1, 2, 3, 4, 5, 6, 7};
    int pre[8] = '{0, 0, 0, 0, 24'h7ff000, 24'hff0000, 24'h800800, 24'h000400};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset values
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      check("R1 reset register", v, 0);
    end
    check("R1 reset overflow", int'(ovfFlag), 0);

    // R2: control readback, bit 6 reads zero
    wr(0, 8'h7f);
    rd(0, v);
    check("R2 control readback", v, 8'h3f);
    wr(0, 0);
    rd(0, v);
    check("R2 control cleared", v, 0);

    // R3 + R7: B written twice then A; result exactly one clock later
    wr(2, 3);
    @(negedge clk);
    rdShadow(v);
    check("R3 no start on B only", v, 0);
    wr(2, 4);
    @(negedge clk);
    rdShadow(v);
    check("R3 no start on repeated B", v, 0);
    wr(1, 5);
    rdShadow(v);
    check("R7 not yet visible", v, 0);
    @(negedge clk);
    rdShadow(v);
    check("R7 visible one clock later", v, 20);
    mAcc = 20;

    // R6: control write restarts the count
    wr(1, 6);
    wr(0, 0);
    wr(2, 7);
    @(negedge clk);
    rdShadow(v);
    check("R6 count discarded", v, 20);
    wr(1, 2);
    @(negedge clk);
    rdShadow(v);
    check("R6 fresh pair starts", v, 14);
    rd(1, v); check("R6 operand A kept", v, 2);
    rd(2, v); check("R6 operand B kept", v, 7);
    wr(0, 8'h40);
    rd(1, v); check("R6 clear operand A", v, 0);
    rd(2, v); check("R6 clear operand B", v, 0);

    // R4: single-operand start
    wr(0, 8'h10);
    wr(1, 3);
    @(negedge clk);
    rdShadow(v);
    check("R4 start on A write", v, 0);
    wr(2, 9);
    @(negedge clk);
    rdShadow(v);
    check("R4 start on B write", v, 27);

    // R5: square copies to both operands, signed and unsigned sweeps
    wr(0, 8'h18);
    wr(2, 8'hf0);
    @(negedge clk);
    rd(1, v); check("R5 copy to A", v, 8'hf0);
    rd(2, v); check("R5 copy to B", v, 8'hf0);
    rdShadow(v); check("R5 signed square", v, 256);
    for (int x = 0; x < 256; x++) begin
      wr(0, 8'h08);
      wr(x[0] ? 1 : 2, x);
      @(negedge clk);
      rdShadow(v);
      check("R5 signed square sweep", v, (sx8(x) * sx8(x)) & 16'hffff);
      wr(0, 8'h09);
      wr(x[0] ? 2 : 1, x);
      @(negedge clk);
      rdShadow(v);
      check("R5 unsigned square sweep", v, x * x);
    end
    rdAcc(mAcc);

    // R8/R10/R11: arithmetic sweeps over corner pairs
    for (int m = 0; m < 8; m++) begin
      if (modes[m][2]) loadAcc(pre[m]);
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          runOp(modes[m], vals[i], vals[j], "sweep");
    end

    // R9/R10: blocked writeback
    loadAcc(24'h123456);
    wr(0, 8'h24);
    wr(1, 2);
    wr(2, 3);
    @(negedge clk);
    rdAcc(v);
    check("R9 accumulator held", v, 24'h123456);
    check("R9 accumulator port held", int'(accOut), 24'h123456);
    rdShadow(v);
    check("R10 result words with block", v, 16'h345c);

    // R13: result words read-only, unsigned select keeps accumulator
    rdShadow(sh0);
    wr(6, 8'haa);
    wr(7, 8'h55);
    rdShadow(v);
    check("R13 result write ignored", v, sh0);
    wr(0, 8'h01);
    rdAcc(v);
    check("R13 select change keeps accumulator", v, 24'h123456);

    // R12: sticky flag
    wr(0, 8'h03);
    wr(1, 1);
    wr(2, 1);
    @(negedge clk);
    check("R11 unsigned negate flags", int'(ovfFlag), 1);
    wr(0, 8'h80);
    rd(0, v);
    check("R12 flag survives bit7 write", v, 8'h80);
    wr(1, 1);
    wr(2, 1);
    @(negedge clk);
    check("R12 flag stays after clean op", int'(ovfFlag), 1);
    rdShadow(v2);
    check("R12 clean op result", v2, 1);
    wr(0, 8'h00);
    check("R12 flag cleared", int'(ovfFlag), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule